// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

This block is one channel of a DMA copy engine. Software programs a control word, a start source address, a start destination address and a unit count through a small register port. On a trigger the channel copies units from source to destination over a 16-bit memory master port. Each unit is a read followed by a write. The trigger can be a hardware line, sampled on its rising edge or on its level, or a request bit written by software.

Three transfer kinds are supported: single (one unit per trigger), block (the whole count back to back) and burst (the whole count, with an idle bus cycle after each group of units). Each kind has an auto-repeat variant that reloads the start addresses and the count when it finishes. Each side of the copy can be a byte or a word. Each address can be held, incremented or decremented.

When a sequence finishes, a sticky completion flag is set, and an interrupt line follows the flag while interrupts are enabled. A stop input ends a running sequence after the unit in flight. This sets both an abort status and the completion flag.

Top module: `dma_channel`

## Requirements
- R1: After reset, all four registers read zero, `irq` is low and `mem_req` is low.
- R2: Register offsets are: 0 control, 1 source, 2 destination, 3 count. Control bits are: [2:0] kind, [4:3] source step, [6:5] destination step, [7] source byte, [8] destination byte, [9] level trigger, [10] enable, [11] request (always reads 0), [12] completion flag, [13] interrupt enable, [14] abort status.
- R3: Kind 1 (block) and kind 5 move the whole count after one trigger. Each unit is a read cycle followed directly by a write cycle, and `mem_req` stays high with no gap.
- R4: Kind 0 (single) and kind 4 move one unit per trigger. With the level bit at 0, one unit is moved per rising edge of `trig_in`, however long the line stays high. With the level bit at 1, units keep moving while `trig_in` is high.
- R5: Kind 2 (burst) and kind 6 move the whole count after one trigger. After every 4 units (the parameter `BURST_LEN`), one cycle with `mem_req` low is inserted.
- R6: Step code 00 holds an address, 10 decrements it and 11 increments it. The step size is 1 for a byte side and 2 for a word side. The address registers read back the current address.
- R7: A byte read uses `mem_rdata[7:0]`. A byte write drives `mem_wdata[15:8]` to zero. A byte moved into a word destination is zero-extended. A word moved into a byte destination writes only its low byte.
- R8: In kinds 0, 1 and 2, finishing the count clears enable, leaves the count register at 0 and sets the completion flag.
- R9: In kinds 4, 5 and 6, finishing the count sets the flag, keeps enable set, and reloads the count and both addresses with their programmed start values.
- R10: The completion flag is never cleared by hardware. Writing 0 to it clears it. `irq` is high exactly while the flag and the interrupt-enable bit are both set.
- R11: `stop_req` while enabled ends the sequence after the unit in flight, or at once if no unit is in flight. This sets abort status and the flag and clears enable. If the unit in flight is the last one, normal completion wins and abort stays 0.
- R12: A request written together with enable starts a sequence. A trigger or a request while enable is 0 moves nothing and leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register offset |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for `cfg_addr` |
| trig_in | input | 1 | Hardware trigger line |
| stop_req | input | 1 | Request to stop the running sequence |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_byte | output | 1 | 1 = byte access, 0 = word access |
| mem_addr | output | AW | Access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access accepted this cycle |
| irq | output | 1 | Interrupt, flag AND interrupt enable |

## Verification
Two events can fall in the same cycle: a stop request and the write acknowledge of the final unit. Both lead to the end of the sequence, but only one of them may set the abort status. The bench raises `stop_req` during the read cycle of a one-unit block, so that the stop is pending on the exact edge where the last write completes, and then expects the flag to be set with abort clear. A second run raises the stop during the third read of an eight-unit block. There it expects exactly three writes, the abort status set, and five units left in the count.

// File: rtl/dma_channel.sv
module dma_channel #(
  parameter int AW        = 16,
  parameter int BURST_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [15:0]   cfg_wdata,
  output logic [15:0]   cfg_rdata,
  input  logic          trig_in,
  input  logic          stop_req,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_byte,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  input  logic          mem_ack,
  output logic          irq
);
  localparam int BCW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [BCW-1:0] BLAST = BCW'(BURST_LEN - 1);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_GAP} st_t;
  st_t st;

  logic [2:0]    kind;
  logic [1:0]    sstep, dstep;
  logic          sbyte, dbyte, lvl, en, flag, ie, abrt;
  logic [AW-1:0] prog_src, prog_dst, cur_src, cur_dst;
  logic [15:0]   prog_cnt, cur_cnt, dbuf;
  logic          trig_q, pend, stop_pend;
  logic [BCW-1:0] bcnt;

  wire ctl_wr    = cfg_we && cfg_addr == 2'd0;
  wire sw_go     = ctl_wr && cfg_wdata[11] && cfg_wdata[10];
  wire go        = pend || (lvl && trig_in);
  wire start     = st == S_IDLE && en && go && cur_cnt != 16'd0 && !stop_pend;
  wire unit_done = st == S_WR && mem_ack;
  wire last      = cur_cnt == 16'd1;
  wire complete  = unit_done && last;
  wire abort_now = (unit_done && !last && stop_pend) || (st == S_IDLE && en && stop_pend);
  wire is_block  = kind[1:0] == 2'b01;
  wire is_burst  = kind[1:0] == 2'b10;
  wire rpt       = kind[2];

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a, input logic [1:0] s,
                                              input logic b);
    logic [AW-1:0] d;
    d = b ? AW'(1) : AW'(2);
    case (s)
      2'b10:   return a - d;
      2'b11:   return a + d;
      default: return a;
    endcase
  endfunction

  assign mem_req   = st == S_RD || st == S_WR;
  assign mem_we    = st == S_WR;
  assign mem_byte  = (st == S_RD) ? sbyte : dbyte;
  assign mem_addr  = (st == S_RD) ? cur_src : cur_dst;
  assign mem_wdata = dbyte ? {8'h00, dbuf[7:0]} : dbuf;
  assign irq       = flag && ie;

  always_comb begin
    case (cfg_addr)
      2'd0:    cfg_rdata = {1'b0, abrt, ie, flag, 1'b0, en, lvl, dbyte, sbyte, dstep, sstep, kind};
      2'd1:    cfg_rdata = 16'(cur_src);
      2'd2:    cfg_rdata = 16'(cur_dst);
      default: cfg_rdata = cur_cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {kind, sstep, dstep, sbyte, dbyte, lvl, en, flag, ie, abrt} <= '0;
      prog_src <= '0; prog_dst <= '0; cur_src <= '0; cur_dst <= '0;
      prog_cnt <= '0; cur_cnt <= '0;
    end else begin
      if (ctl_wr) begin
        kind  <= cfg_wdata[2:0];
        sstep <= cfg_wdata[4:3];
        dstep <= cfg_wdata[6:5];
        sbyte <= cfg_wdata[7];
        dbyte <= cfg_wdata[8];
        lvl   <= cfg_wdata[9];
        en    <= cfg_wdata[10];
        flag  <= cfg_wdata[12];
        ie    <= cfg_wdata[13];
        abrt  <= cfg_wdata[14];
      end
      if (cfg_we && cfg_addr == 2'd1) begin prog_src <= AW'(cfg_wdata); cur_src <= AW'(cfg_wdata); end
      if (cfg_we && cfg_addr == 2'd2) begin prog_dst <= AW'(cfg_wdata); cur_dst <= AW'(cfg_wdata); end
      if (cfg_we && cfg_addr == 2'd3) begin prog_cnt <= cfg_wdata; cur_cnt <= cfg_wdata; end
      if (unit_done) begin
        cur_src <= step_addr(cur_src, sstep, sbyte);
        cur_dst <= step_addr(cur_dst, dstep, dbyte);
        cur_cnt <= cur_cnt - 16'd1;
      end
      if (complete) begin
        flag <= 1'b1;
        if (rpt) begin
          cur_src <= prog_src; cur_dst <= prog_dst; cur_cnt <= prog_cnt;
        end else begin
          en <= 1'b0;
        end
      end
      if (abort_now) begin
        en <= 1'b0; abrt <= 1'b1; flag <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= 1'b0; pend <= 1'b0; stop_pend <= 1'b0;
    end else begin
      trig_q <= trig_in;
      pend   <= sw_go || (en && ((pend && !start) || (!lvl && trig_in && !trig_q)));
      if (!en || complete || abort_now) stop_pend <= 1'b0;
      else if (stop_req)                stop_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; bcnt <= '0; dbuf <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin st <= S_RD; bcnt <= '0; end
        S_RD: if (mem_ack) begin
          dbuf <= sbyte ? {8'h00, mem_rdata[7:0]} : mem_rdata;
          st   <= S_WR;
        end
        S_WR: if (mem_ack) begin
          bcnt <= bcnt + BCW'(1);
          if (complete || abort_now || !en || !(is_block || is_burst)) st <= S_IDLE;
          else if (is_burst && bcnt == BLAST) begin st <= S_GAP; bcnt <= '0; end
          else st <= S_RD;
        end
        S_GAP: st <= S_RD;
      endcase
    end
  end

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !ctl_wr) |=> flag);
  a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && mem_ack) |=> (mem_req && mem_we));
  a_r8_done_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && !rpt && !ctl_wr) |=> !en);
  a_r9_count_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && rpt && !(cfg_we && cfg_addr == 2'd3)) |=> (cur_cnt == prog_cnt));
  a_r6_fixed_source: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && sstep == 2'b00 && !(complete && rpt) && !(cfg_we && cfg_addr == 2'd1))
      |=> $stable(cur_src));
  a_r11_abort_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abrt) |-> flag);
endmodule

// File: tb/dma_channel_test.sv
`timescale 1ns/1ps
module dma_channel_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cfg_we = 1'b0, trig_in = 1'b0, stop_req = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [15:0] cfg_wdata = 16'd0, cfg_rdata, mem_wdata, mem_rdata, mem_addr;
  logic mem_req, mem_we, mem_byte, mem_ack, irq;

  dma_channel uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .trig_in(trig_in), .stop_req(stop_req), .mem_req(mem_req),
    .mem_we(mem_we), .mem_byte(mem_byte), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .irq(irq));

  int checks = 0, errors = 0, nwr = 0;
  typedef struct { logic [15:0] a; logic [15:0] d; logic b; string r; } wr_t;
  wr_t exp_q[$];
  wr_t got;
  logic [7:0] m [256];

  assign mem_ack   = mem_req;
  assign mem_rdata = mem_byte ? {8'h00, m[mem_addr[7:0]]}
                              : {m[{mem_addr[7:1], 1'b1}], m[{mem_addr[7:1], 1'b0}]};

  always @(posedge clk)
    if (mem_req && mem_we) begin
      if (mem_byte) m[mem_addr[7:0]] = mem_wdata[7:0];
      else begin
        m[{mem_addr[7:1], 1'b0}] = mem_wdata[7:0];
        m[{mem_addr[7:1], 1'b1}] = mem_wdata[15:8];
      end
    end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && mem_req && mem_we) begin
      nwr++;
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected write", int'(mem_addr), 0);
      else begin
        got = exp_q.pop_front();
        chk(mem_addr == got.a, {got.r, " write address"}, int'(mem_addr), int'(got.a));
        chk(mem_wdata == got.d && mem_byte == got.b, {got.r, " write data/width"},
            int'({mem_byte, mem_wdata}), int'({got.b, got.d}));
      end
    end

  function automatic logic [15:0] nxt(input logic [15:0] a, input logic [1:0] s, input logic b);
    if (s == 2'b11) return a + (b ? 16'd1 : 16'd2);
    if (s == 2'b10) return a - (b ? 16'd1 : 16'd2);
    return a;
  endfunction

  task automatic push(input logic [15:0] s0, input logic [15:0] d0, input int n,
                      input logic [1:0] ss, input logic [1:0] ds, input logic sb,
                      input logic db, input string r);
    logic [15:0] s, d, v;
    wr_t x;
    s = s0; d = d0;
    for (int k = 0; k < n; k++) begin
      v = sb ? {8'h00, m[s[7:0]]} : {m[{s[7:1], 1'b1}], m[{s[7:1], 1'b0}]};
      x.a = d; x.d = db ? {8'h00, v[7:0]} : v; x.b = db; x.r = r;
      exp_q.push_back(x);
      s = nxt(s, ss, sb); d = nxt(d, ds, db);
    end
  endtask

  function automatic logic [15:0] ctlw(input logic [2:0] kd, input logic [1:0] ss,
      input logic [1:0] ds, input logic sb, input logic db, input logic lv, input logic en,
      input logic rq, input logic ie);
    return {1'b0, 1'b0, ie, 1'b0, rq, en, lv, db, sb, ds, ss, kd};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0; cfg_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata; cfg_addr = 2'd0;
  endtask

  task automatic prog(input logic [15:0] s, input logic [15:0] d, input logic [15:0] n);
    wr(2'd1, s); wr(2'd2, d); wr(2'd3, n);
  endtask

  task automatic count_idle(output int idle);
    bit started;
    started = 1'b0; idle = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (cfg_rdata[12]) break;
      if (mem_req) started = 1'b1;
      else if (started) idle++;
    end
  endtask

  task automatic wait_reads(input int k);
    int seen;
    seen = 0;
    while (seen < k) begin
      @(negedge clk);
      if (mem_req && !mem_we) seen++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int idle, w0;
    for (int i = 0; i < 256; i++) m[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk(v == 16'd0, "R1 register reset", v, 0);
    end
    chk(!irq && !mem_req, "R1 irq/mem_req low", {irq, mem_req}, 0);

    // R3 block, words, increment; R8 completion; R10 irq
    prog(16'h0010, 16'h0080, 16'd4);
    push(16'h0010, 16'h0080, 4, 2'b11, 2'b11, 1'b0, 1'b0, "R3");
    wr(2'd0, ctlw(3'd1, 2'b11, 2'b11, 0, 0, 0, 1, 1, 1));
    count_idle(idle);
    chk(idle == 0, "R3 block has no bus gap", idle, 0);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all units written", exp_q.size(), 0);
    rd(2'd0, v); chk(v[12] && !v[10] && !v[14], "R8 flag set, enable clear", v, 16'h2000);
    chk(!v[11], "R2 request reads zero", v[11], 0);
    rd(2'd3, v); chk(v == 0, "R8 count reads zero", v, 0);
    rd(2'd1, v); chk(v == 16'h0018, "R6 source incremented by 2", v, 16'h18);
    rd(2'd2, v); chk(v == 16'h0088, "R6 destination incremented by 2", v, 16'h88);
    chk(irq, "R10 irq with flag and enable", irq, 1);

    // R10 flag sticky, cleared by software
    repeat (20) @(negedge clk);
    rd(2'd0, v); chk(v[12] && irq, "R10 flag sticky", v[12], 1);
    wr(2'd0, ctlw(3'd0, 0, 0, 0, 0, 0, 0, 0, 1));
    #1 chk(!irq, "R10 write zero clears flag", irq, 0);
    wr(2'd0, 16'h1000);
    #1 chk(!irq, "R10 flag without enable keeps irq low", irq, 0);
    rd(2'd0, v); chk(v[12], "R10 flag written to one", v[12], 1);

    // R5 burst gap
    prog(16'h0020, 16'h00A0, 16'd6);
    push(16'h0020, 16'h00A0, 6, 2'b11, 2'b11, 1'b0, 1'b0, "R5");
    wr(2'd0, ctlw(3'd2, 2'b11, 2'b11, 0, 0, 0, 1, 1, 0));
    count_idle(idle);
    chk(idle == 1, "R5 one idle cycle after 4 units", idle, 1);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all burst units written", exp_q.size(), 0);

    // R4 single, edge trigger
    prog(16'h0030, 16'h00C0, 16'd3);
    push(16'h0030, 16'h00C0, 3, 2'b11, 2'b11, 1'b0, 1'b0, "R4");
    wr(2'd0, ctlw(3'd0, 2'b11, 2'b11, 0, 0, 0, 1, 0, 0));
    w0 = nwr;
    repeat (5) @(negedge clk);
    chk(nwr == w0, "R4 nothing without trigger", nwr - w0, 0);
    @(negedge clk) trig_in = 1'b1; @(negedge clk) trig_in = 1'b0;
    repeat (6) @(negedge clk);
    chk(nwr == w0 + 1, "R4 one unit per edge", nwr - w0, 1);
    @(negedge clk) trig_in = 1'b1;
    repeat (10) @(negedge clk);
    trig_in = 1'b0;
    repeat (4) @(negedge clk);
    chk(nwr == w0 + 2, "R4 held line gives one unit", nwr - w0, 2);
    @(negedge clk) trig_in = 1'b1; @(negedge clk) trig_in = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd0, v); chk(v[12] && !v[10] && nwr == w0 + 3, "R4 single completes", v, 16'h1000);

    // R4 single, level trigger
    prog(16'h0000, 16'h00D0, 16'd3);
    push(16'h0000, 16'h00D0, 3, 2'b11, 2'b11, 1'b0, 1'b0, "R4");
    wr(2'd0, ctlw(3'd0, 2'b11, 2'b11, 0, 0, 1, 1, 0, 0));
    w0 = nwr;
    @(negedge clk) trig_in = 1'b1;
    repeat (15) @(negedge clk);
    trig_in = 1'b0;
    chk(nwr == w0 + 3, "R4 level keeps moving units", nwr - w0, 3);

    // R6/R7 byte to word, source decrement
    prog(16'h000F, 16'h00E0, 16'd3);
    push(16'h000F, 16'h00E0, 3, 2'b10, 2'b11, 1'b1, 1'b0, "R7");
    wr(2'd0, ctlw(3'd1, 2'b10, 2'b11, 1, 0, 0, 1, 1, 0));
    repeat (12) @(negedge clk);
    rd(2'd1, v); chk(v == 16'h000C, "R6 byte source decrements by 1", v, 16'hC);
    rd(2'd2, v); chk(v == 16'h00E6, "R6 word destination steps by 2", v, 16'hE6);

    // R6/R7 word to byte, fixed destination
    prog(16'h0004, 16'h00F0, 16'd2);
    push(16'h0004, 16'h00F0, 2, 2'b11, 2'b00, 1'b0, 1'b1, "R7");
    wr(2'd0, ctlw(3'd1, 2'b11, 2'b00, 0, 1, 0, 1, 1, 0));
    repeat (10) @(negedge clk);
    rd(2'd2, v); chk(v == 16'h00F0, "R6 fixed destination holds", v, 16'hF0);

    // R6/R7 byte to byte, fixed source, destination decrement
    prog(16'h0005, 16'h00EF, 16'd2);
    push(16'h0005, 16'h00EF, 2, 2'b00, 2'b10, 1'b1, 1'b1, "R7");
    wr(2'd0, ctlw(3'd1, 2'b00, 2'b10, 1, 1, 0, 1, 1, 0));
    repeat (10) @(negedge clk);
    rd(2'd1, v); chk(v == 16'h0005, "R6 fixed source holds", v, 16'h5);
    rd(2'd2, v); chk(v == 16'h00ED, "R6 byte destination decrements by 1", v, 16'hED);
    chk(exp_q.size() == 0, "R7 all width cases written", exp_q.size(), 0);

    // R9 repeated block
    prog(16'h0010, 16'h0090, 16'd2);
    push(16'h0010, 16'h0090, 2, 2'b11, 2'b11, 1'b0, 1'b0, "R9");
    wr(2'd0, ctlw(3'd5, 2'b11, 2'b11, 0, 0, 0, 1, 1, 0));
    repeat (10) @(negedge clk);
    rd(2'd0, v); chk(v[10] && v[12], "R9 enable stays, flag set", v, 16'h1400);
    rd(2'd3, v); chk(v == 16'd2, "R9 count reloaded", v, 2);
    rd(2'd1, v); chk(v == 16'h0010, "R9 source reloaded", v, 16'h10);
    rd(2'd2, v); chk(v == 16'h0090, "R9 destination reloaded", v, 16'h90);
    push(16'h0010, 16'h0090, 2, 2'b11, 2'b11, 1'b0, 1'b0, "R9");
    wr(2'd0, ctlw(3'd5, 2'b11, 2'b11, 0, 0, 0, 1, 1, 0));
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R9 second pass repeats", exp_q.size(), 0);
    wr(2'd0, 16'h0000);

    // R11 stop mid block
    prog(16'h0020, 16'h00A0, 16'd8);
    push(16'h0020, 16'h00A0, 8, 2'b11, 2'b11, 1'b0, 1'b0, "R11");
    w0 = nwr;
    wr(2'd0, ctlw(3'd1, 2'b11, 2'b11, 0, 0, 0, 1, 1, 0));
    wait_reads(3);
    stop_req = 1'b1; @(negedge clk) stop_req = 1'b0;
    repeat (10) @(negedge clk);
    chk(nwr == w0 + 3, "R11 stop after unit in flight", nwr - w0, 3);
    rd(2'd0, v); chk(v[14] && v[12] && !v[10], "R11 abort, flag, disabled", v, 16'h5000);
    rd(2'd3, v); chk(v == 16'd5, "R11 remaining count", v, 5);
    chk(exp_q.size() == 5, "R11 unsent units", exp_q.size(), 5);
    exp_q.delete();

    // R11 stop on the last unit: completion wins
    prog(16'h0002, 16'h00B0, 16'd1);
    push(16'h0002, 16'h00B0, 1, 2'b11, 2'b11, 1'b0, 1'b0, "R11");
    wr(2'd0, ctlw(3'd1, 2'b11, 2'b11, 0, 0, 0, 1, 1, 0));
    wait_reads(1);
    stop_req = 1'b1; @(negedge clk) stop_req = 1'b0;
    repeat (5) @(negedge clk);
    rd(2'd0, v); chk(v[12] && !v[14] && !v[10], "R11 last unit completes, no abort", v, 16'h1000);
    chk(exp_q.size() == 0, "R11 last unit written", exp_q.size(), 0);

    // R11 stop while idle and enabled
    prog(16'h0002, 16'h00B0, 16'd2);
    wr(2'd0, ctlw(3'd0, 2'b11, 2'b11, 0, 0, 0, 1, 0, 0));
    w0 = nwr;
    @(negedge clk) stop_req = 1'b1; @(negedge clk) stop_req = 1'b0;
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk(v[14] && !v[10] && nwr == w0, "R11 idle stop aborts at once", v, 16'h5000);

    // R12 disabled channel ignores triggers and requests
    prog(16'h0002, 16'h00B0, 16'd2);
    wr(2'd0, ctlw(3'd1, 2'b11, 2'b11, 0, 0, 0, 0, 0, 0));
    w0 = nwr;
    @(negedge clk) trig_in = 1'b1; @(negedge clk) trig_in = 1'b0;
    wr(2'd0, ctlw(3'd1, 2'b11, 2'b11, 0, 0, 0, 0, 1, 0));
    repeat (8) @(negedge clk);
    chk(nwr == w0 && !mem_req, "R12 nothing moves while disabled", nwr - w0, 0);
    rd(2'd3, v); chk(v == 16'd2, "R12 count unchanged", v, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule